// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block takes interrupt reports from PCI devices and turns them into a level vector for a 16-input interrupt controller. Each report names the device by its device/function number, gives the interrupt pin the device used (0 to 3) and the new level on that pin. The block folds the pin onto one of four shared PCI interrupt lines using a fixed slot table. A few on-board slots are hard-wired to particular lines. A group of four expansion slots rotates the pin by the slot's position. Every other slot keeps its pin number as the line.

Each of the four lines remembers the last level reported for it. A small route table holds one 8-bit entry per line, naming the controller input that the line feeds. Any entry of 16 or more leaves the line unconnected. Each controller input is the wired-OR of the stored levels of all lines routed to it. This lets two or more lines share one controller input.

The output vector is formed combinationally from the stored levels and the route entries. A new level or a new route entry therefore shows on the vector in the cycle right after the clock edge that captured it.

Top module: `pci_irq_router`

## Requirements
- R1: The slot number is the device/function number shifted right by 3. The low 3 bits (function) never affect which line is chosen.
- R2: Slot 10 drives line 3. Slots 11 and 12 drive line 0, whatever the pin.
- R3: Slots 18, 19, 20 and 21 drive line ((slot - 18) + pin) mod 4.
- R4: Any other slot drives the line whose number equals the pin.
- R5: A report (evt_valid high for one cycle) sets the stored level of its line to evt_level at that clock edge. Without a report, the stored levels hold.
- R6: A route write (rt_wr_en high) replaces entry rt_wr_idx with the 8-bit rt_wr_data at that clock edge. The new routing shows on irq_out from the following cycle.
- R7: A line whose route entry is 16 or larger affects no bit of irq_out.
- R8: Bit n of irq_out equals the OR of the stored levels of every line whose route entry equals n.
- R9: During and after reset, all stored levels are 0, all route entries are 0x80 (unconnected) and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe for an interrupt report |
| evt_devfn | input | 8 | Device/function number of the reporting device |
| evt_pin | input | 2 | Interrupt pin used by the device (0 to 3) |
| evt_level | input | 1 | New level on that pin |
| rt_wr_en | input | 1 | Route table write strobe |
| rt_wr_idx | input | 2 | Line whose route entry is written |
| rt_wr_data | input | 8 | New route entry (controller input number, 16 or more = unconnected) |
| irq_out | output | 16 | Level of each interrupt controller input |

## Verification
The bench builds the block with its default parameters: four lines, 16 controller inputs, 8-bit route entries and 8-bit device/function numbers. At that size every device/function value can be tried with every pin. This covers the whole slot table, including the function bits and the wrap in the expansion rotation. The 8-bit route entries make it possible to write values just above 15 and values with the top bit set, so unconnected routes are tested at several distances from the last valid input. Hundreds of route and level mixes, some placing several lines on one input, test the wired-OR against a model computed in the bench.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    // Slot classes recognised by the swizzle stage
    typedef enum logic [1:0] {
        SLOT_FIXED_HI,   // on-board slot tied to a fixed line
        SLOT_FIXED_LO,   // on-board slots tied to line 0
        SLOT_ROTATE,     // expansion slots: pin rotated by slot position
        SLOT_PASS        // anything else: pin is the line
    } slot_class_e;

    localparam logic [7:0] ROUTE_RESET = 8'h80;

endpackage

// File: rtl/irq_swizzle.sv
`timescale 1ns/1ps
module irq_swizzle
    import irq_route_pkg::*;
#(
    parameter int DEVFN_W   = 8,
    parameter int NUM_LINES = 4,
    parameter int SLOT_HI   = 10,
    parameter int HI_LINE   = 3,
    parameter int SLOT_LO_A = 11,
    parameter int SLOT_LO_B = 12,
    parameter int ROT_BASE  = 18,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int SLOT_W   = DEVFN_W - 3
) (
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [LINE_W-1:0]  pin,
    output logic [LINE_W-1:0]  line
);

    logic [SLOT_W-1:0] slot;
    logic [LINE_W-1:0] rot_ofs;
    slot_class_e       cls;

    assign slot    = devfn[DEVFN_W-1:3];
    assign rot_ofs = LINE_W'(slot - SLOT_W'(ROT_BASE));

    always_comb begin
        if (slot == SLOT_W'(SLOT_HI))
            cls = SLOT_FIXED_HI;
        else if (slot == SLOT_W'(SLOT_LO_A) || slot == SLOT_W'(SLOT_LO_B))
            cls = SLOT_FIXED_LO;
        else if (slot >= SLOT_W'(ROT_BASE) && slot < SLOT_W'(ROT_BASE + NUM_LINES))
            cls = SLOT_ROTATE;
        else
            cls = SLOT_PASS;
    end

    always_comb begin
        unique case (cls)
            SLOT_FIXED_HI: line = LINE_W'(HI_LINE);
            SLOT_FIXED_LO: line = '0;
            SLOT_ROTATE:   line = rot_ofs + pin;
            SLOT_PASS:     line = pin;
            default:       line = pin;
        endcase
    end

endmodule

// File: rtl/irq_line_store.sv
`timescale 1ns/1ps
module irq_line_store #(
    parameter int NUM_LINES = 4,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_valid,
    input  logic [LINE_W-1:0]    upd_line,
    input  logic                 upd_level,
    output logic [NUM_LINES-1:0] levels
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            levels <= '0;
        else if (upd_valid)
            levels[upd_line] <= upd_level;
    end

    // R5
    level_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> levels[$past(upd_line)] == $past(upd_level));

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(levels));

endmodule

// File: rtl/irq_route_table.sv
`timescale 1ns/1ps
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ROUTE_W   = 8,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [LINE_W-1:0]            wr_idx,
    input  logic [ROUTE_W-1:0]           wr_data,
    output logic [NUM_LINES*ROUTE_W-1:0] routes
);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_entry
        logic [ROUTE_W-1:0] entry_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q <= ROUTE_W'(ROUTE_RESET);
            else if (wr_en && wr_idx == LINE_W'(k))
                entry_q <= wr_data;
        end

        assign routes[k*ROUTE_W +: ROUTE_W] = entry_q;

        // R6
        route_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == LINE_W'(k)) |=> entry_q == $past(wr_data));
    end

endmodule

// File: rtl/irq_route_merge.sv
`timescale 1ns/1ps
module irq_route_merge #(
    parameter int NUM_LINES  = 4,
    parameter int NUM_INPUTS = 16,
    parameter int ROUTE_W    = 8
) (
    input  logic [NUM_LINES-1:0]         levels,
    input  logic [NUM_LINES*ROUTE_W-1:0] routes,
    output logic [NUM_INPUTS-1:0]        irq_out
);

    for (genvar n = 0; n < NUM_INPUTS; n++) begin : g_input
        logic [NUM_LINES-1:0] hit;
        for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
            assign hit[k] = levels[k] &&
                (routes[k*ROUTE_W +: ROUTE_W] == ROUTE_W'(n));
        end
        assign irq_out[n] = |hit;
    end

endmodule

// File: rtl/pci_irq_router.sv
`timescale 1ns/1ps
module pci_irq_router #(
    parameter int DEVFN_W    = 8,
    parameter int NUM_LINES  = 4,
    parameter int NUM_INPUTS = 16,
    parameter int ROUTE_W    = 8,
    localparam int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_valid,
    input  logic [DEVFN_W-1:0]    evt_devfn,
    input  logic [LINE_W-1:0]     evt_pin,
    input  logic                  evt_level,
    input  logic                  rt_wr_en,
    input  logic [LINE_W-1:0]     rt_wr_idx,
    input  logic [ROUTE_W-1:0]    rt_wr_data,
    output logic [NUM_INPUTS-1:0] irq_out
);

    logic [LINE_W-1:0]            sw_line;
    logic [NUM_LINES-1:0]         line_lvl;
    logic [NUM_LINES*ROUTE_W-1:0] route_vec;
    logic                         all_open;

    irq_swizzle #(
        .DEVFN_W   (DEVFN_W),
        .NUM_LINES (NUM_LINES)
    ) u_swizzle (
        .devfn (evt_devfn),
        .pin   (evt_pin),
        .line  (sw_line)
    );

    irq_line_store #(
        .NUM_LINES (NUM_LINES)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (evt_valid),
        .upd_line  (sw_line),
        .upd_level (evt_level),
        .levels    (line_lvl)
    );

    irq_route_table #(
        .NUM_LINES (NUM_LINES),
        .ROUTE_W   (ROUTE_W)
    ) u_routes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rt_wr_en),
        .wr_idx  (rt_wr_idx),
        .wr_data (rt_wr_data),
        .routes  (route_vec)
    );

    irq_route_merge #(
        .NUM_LINES  (NUM_LINES),
        .NUM_INPUTS (NUM_INPUTS),
        .ROUTE_W    (ROUTE_W)
    ) u_merge (
        .levels  (line_lvl),
        .routes  (route_vec),
        .irq_out (irq_out)
    );

    always_comb begin
        all_open = 1'b1;
        for (int k = 0; k < NUM_LINES; k++)
            if (route_vec[k*ROUTE_W +: ROUTE_W] < ROUTE_W'(NUM_INPUTS))
                all_open = 1'b0;
    end

    // R7
    open_routes_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_open |-> irq_out == '0);

    // R8
    merge_no_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= $countones(line_lvl));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> irq_out == '0);

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !rt_wr_en) |=> $stable(irq_out));

endmodule

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/1ps
module pci_irq_router_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_valid;
    logic [7:0]  evt_devfn;
    logic [1:0]  evt_pin;
    logic        evt_level;
    logic        rt_wr_en;
    logic [1:0]  rt_wr_idx;
    logic [7:0]  rt_wr_data;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pci_irq_router u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_devfn  (evt_devfn),
        .evt_pin    (evt_pin),
        .evt_level  (evt_level),
        .rt_wr_en   (rt_wr_en),
        .rt_wr_idx  (rt_wr_idx),
        .rt_wr_data (rt_wr_data),
        .irq_out    (irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: irq_out=%04h expected %04h", req, act, exp);
        end
    endtask

    task automatic send_evt(input int devfn, input int pin, input bit lvl);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_devfn = 8'(devfn);
        evt_pin   = 2'(pin);
        evt_level = lvl;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr_route(input int idx, input int val);
        @(negedge clk);
        rt_wr_en   = 1'b1;
        rt_wr_idx  = 2'(idx);
        rt_wr_data = 8'(val);
        @(negedge clk);
        rt_wr_en = 1'b0;
    endtask

    function automatic int exp_line(input int devfn, input int pin);
        int slot = devfn / 8;
        if (slot == 10) return 3;
        if (slot == 11 || slot == 12) return 0;
        if (slot >= 18 && slot <= 21) return (slot - 18 + pin) % 4;
        return pin;
    endfunction

    function automatic string slot_req(input int devfn);
        int slot = devfn / 8;
        if (slot >= 10 && slot <= 12) return "R1/R2";
        if (slot >= 18 && slot <= 21) return "R1/R3";
        return "R1/R4";
    endfunction

    initial begin
        int rt[4];
        int lv[4];
        logic [15:0] e;
        rst_n = 1'b0; evt_valid = 1'b0; evt_devfn = '0; evt_pin = '0;
        evt_level = 1'b0; rt_wr_en = 1'b0; rt_wr_idx = '0; rt_wr_data = '0;
        repeat (3) @(negedge clk);
        chk(irq_out == 16'h0, "R9 during reset", irq_out, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_out == 16'h0, "R9 after reset", irq_out, 16'h0);

        // R9: routes start unconnected, so raised lines reach nothing
        for (int k = 0; k < 4; k++) send_evt(0, k, 1'b1);
        chk(irq_out == 16'h0, "R9 routes reset unconnected", irq_out, 16'h0);

        // R6: a route write shows the following cycle; R5 the level holds
        wr_route(0, 5);
        chk(irq_out == 16'h0020, "R6 route write visible", irq_out, 16'h0020);
        repeat (5) @(negedge clk);
        chk(irq_out == 16'h0020, "R5 level held", irq_out, 16'h0020);
        wr_route(0, 16);
        chk(irq_out == 16'h0, "R7 route 16 unconnected", irq_out, 16'h0);
        for (int k = 0; k < 4; k++) send_evt(0, k, 1'b0);

        // R1-R4 sweep: line k routed to input k
        for (int k = 0; k < 4; k++) wr_route(k, k);
        for (int d = 0; d < 256; d++) begin
            for (int p = 0; p < 4; p++) begin
                e = 16'(1 << exp_line(d, p));
                send_evt(d, p, 1'b1);
                chk(irq_out == e, slot_req(d), irq_out, e);
                send_evt(d, p, 1'b0);
                chk(irq_out == 16'h0, "R5 level cleared", irq_out, 16'h0);
            end
        end

        // R7 / R8: route and level mixes, shared inputs included
        for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < 4; k++) begin
                rt[k] = (i * 7 + k * 13) % 22;
                if (rt[k] >= 20) rt[k] = 8'h80 + rt[k];
                if (i % 11 == k) rt[k] = 255;
                if (i % 5 == 0 && k > 0) rt[k] = rt[0];
                lv[k] = ((i ^ (i >> 2)) >> k) & 1;
            end
            for (int k = 0; k < 4; k++) begin
                wr_route(k, rt[k]);
                send_evt(0, k, lv[k][0]);
            end
            e = '0;
            for (int k = 0; k < 4; k++)
                if (rt[k] < 16 && lv[k] != 0) e[rt[k]] = 1'b1;
            chk(irq_out == e, "R7/R8 route merge", irq_out, e);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: irq_out=%04h expected completion", irq_out);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule